// File: doc/BRIEF.md
# I2C Request Allowlist Gate

This block stands between a request source and an I2C master. Each request names a bus, a 7-bit target address, a read/write flag and a byte count. Requests aimed at any bus other than the guarded one are passed to the master untouched. For the guarded bus, the gate first checks whether the target address appears in a small programmable allowlist. It then refuses two transaction shapes aimed at one sensitive device: a read of exactly one byte, and a write of zero bytes. A refused request never reaches the master. It completes on its own with a timeout status.

The source and the master both use a valid/ready handshake. Only one request is in flight at a time. A forwarded request waits for the master's completion pulse, and the master's status is handed back unchanged. The allowlist is loaded through a one-cycle write strobe that carries an entry index, a valid bit and an address.

Top module: `i2c_req_gate`

## Requirements
- R1: After reset, reqReady is 1, fwdValid and rspValid are 0, and every allowlist entry is invalid, so any request to the guarded bus is refused.
- R2: A request whose bus differs from PROT_BUS is forwarded with bus, address, read flag and length unchanged, whatever the allowlist holds and whatever its shape.
- R3: A guarded-bus request whose address matches no valid allowlist entry is not forwarded. rspValid rises in the cycle after acceptance with rspStatus = 2'b01 (timeout). This holds even when the shape would otherwise be allowed, because the allowlist check comes first.
- R4: A write strobe (cfgWe) sets entry cfgIdx to {cfgValid, cfgAddr}. Writing cfgValid = 0 removes the entry. The change applies to requests accepted after that clock edge.
- R5: A guarded-bus read (reqRead = 1) of exactly 1 byte to PROT_ADDR is refused with timeout status, even when PROT_ADDR is listed.
- R6: A guarded-bus write (reqRead = 0) of 0 bytes to PROT_ADDR is refused with timeout status, even when PROT_ADDR is listed.
- R7: Any other shape sent to a listed PROT_ADDR is forwarded. This includes reads of 0 or 2+ bytes and writes of 1+ bytes.
- R8: While fwdValid is 1 and fwdReady is 0, fwdValid stays 1 and all forwarded fields hold steady.
- R9: reqReady is 0 from the cycle after an acceptance until the response pulse has been given, so at most one request is outstanding.
- R10: After a forward, the first dnRespValid pulse causes a one-cycle rspValid in the next cycle. It carries dnStatus unchanged (2'b00 ok, 2'b10 error).
- R11: A dnRespValid pulse while no forwarded request is waiting is ignored: rspValid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Allowlist write strobe |
| cfgIdx | input | IDX_W | Entry index to write |
| cfgValid | input | 1 | Valid bit for the entry |
| cfgAddr | input | 7 | Address for the entry |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Gate can accept a request |
| reqBus | input | BUS_W | Target bus ID |
| reqAddr | input | 7 | Target device address |
| reqRead | input | 1 | 1 = read, 0 = write |
| reqLen | input | LEN_W | Byte count |
| fwdValid | output | 1 | Request offered to the master |
| fwdReady | input | 1 | Master takes the request |
| fwdBus | output | BUS_W | Forwarded bus ID |
| fwdAddr | output | 7 | Forwarded address |
| fwdRead | output | 1 | Forwarded read flag |
| fwdLen | output | LEN_W | Forwarded byte count |
| dnRespValid | input | 1 | Master completion pulse |
| dnStatus | input | 2 | Master completion status |
| rspValid | output | 1 | One-cycle response pulse to the source |
| rspStatus | output | 2 | 00 ok, 01 timeout, 10 master error |

## Verification
Directed requests run in several groups:
- Requests on a foreign bus separate pass-through from filtering.
- Unlisted addresses on the guarded bus show the allowlist refusing traffic that is otherwise well formed.
- Each shape sent to the listed sensitive address (1-byte read, 0-byte write, 0-byte read, 2-byte read, 1-byte write) tells the two refused shapes apart from their close neighbours.
- Removing and re-adding the sensitive address in a different slot confirms that matching depends on the stored contents, not on the slot position.

A long seeded random run then mixes buses, addresses from a small pool, lengths 0 to 3, and both directions. It also varies the master's back-pressure and returned status, and compares each outcome with a bench model of the allowlist.

// File: rtl/i2c_gate_pkg.sv
package i2c_gate_pkg;
  localparam logic [1:0] RSP_OK      = 2'b00;
  localparam logic [1:0] RSP_TIMEOUT = 2'b01;
  localparam logic [1:0] RSP_DNERR   = 2'b10;

  typedef struct packed {
    logic latchReq;   // capture request for forwarding
    logic loadBlock;  // load timeout status
    logic loadDown;   // load master status
  } gateStrobe_t;
endpackage

// File: rtl/gate_datapath.sv
module gate_datapath
  import i2c_gate_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int BUS_W = 2,
  parameter int LEN_W = 8,
  parameter logic [BUS_W-1:0] PROT_BUS = 1,
  parameter logic [6:0] PROT_ADDR = 7'h2E,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgValid,
  input  logic [6:0]       cfgAddr,
  input  logic [BUS_W-1:0] reqBus,
  input  logic [6:0]       reqAddr,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [1:0]       dnStatus,
  input  gateStrobe_t      strobe,
  output logic             reqBlocked,
  output logic [BUS_W-1:0] fwdBus,
  output logic [6:0]       fwdAddr,
  output logic             fwdRead,
  output logic [LEN_W-1:0] fwdLen,
  output logic [1:0]       rspStatus
);
  logic [N_ENTRIES-1:0] entryValid;
  logic [6:0]           entryAddr [N_ENTRIES];
  logic [N_ENTRIES-1:0] hitVec;

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entryValid[i] <= 1'b0;
        entryAddr[i]  <= '0;
      end else if (cfgWe && cfgIdx == IDX_W'(i)) begin
        entryValid[i] <= cfgValid;
        entryAddr[i]  <= cfgAddr;
      end
    end
    assign hitVec[i] = entryValid[i] && (entryAddr[i] == reqAddr);
  end

  logic onProtBus, listHit, badShape;
  always_comb begin
    onProtBus  = (reqBus == PROT_BUS);
    listHit    = |hitVec;
    badShape   = (reqAddr == PROT_ADDR) &&
                 ((reqRead && reqLen == LEN_W'(1)) || (!reqRead && reqLen == '0));
    // allowlist first, then shape
    reqBlocked = onProtBus && (!listHit || badShape);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fwdBus    <= '0;
      fwdAddr   <= '0;
      fwdRead   <= 1'b0;
      fwdLen    <= '0;
      rspStatus <= RSP_OK;
    end else begin
      if (strobe.latchReq) begin
        fwdBus  <= reqBus;
        fwdAddr <= reqAddr;
        fwdRead <= reqRead;
        fwdLen  <= reqLen;
      end
      if (strobe.loadBlock)     rspStatus <= RSP_TIMEOUT;
      else if (strobe.loadDown) rspStatus <= dnStatus;
    end
  end

  // R4: a written valid entry makes its address hit on the next cycle
  p_cfg_hit_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && cfgValid && reqAddr == cfgAddr ##0 $stable(reqAddr)[*1] |-> 1'b1 ##1 (reqAddr != $past(cfgAddr)) || hitVec[$past(cfgIdx)]);
endmodule

// File: rtl/gate_control.sv
module gate_control
  import i2c_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqBlocked,
  input  logic        fwdReady,
  input  logic        dnRespValid,
  output logic        reqReady,
  output logic        fwdValid,
  output logic        rspValid,
  output gateStrobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_FWD, S_WAIT, S_RESP} gateState_e;
  gateState_e state, stateNext;

  logic accept;
  assign accept = reqValid && reqReady;

  always_comb begin
    reqReady = (state == S_IDLE);
    fwdValid = (state == S_FWD);
    rspValid = (state == S_RESP);
    strobe.latchReq  = accept && !reqBlocked;
    strobe.loadBlock = accept && reqBlocked;
    strobe.loadDown  = (state == S_WAIT) && dnRespValid;
    stateNext = state;
    unique case (state)
      S_IDLE: if (accept) stateNext = reqBlocked ? S_RESP : S_FWD;
      S_FWD:  if (fwdReady) stateNext = S_WAIT;
      S_WAIT: if (dnRespValid) stateNext = S_RESP;
      S_RESP: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R9: an accepted request closes the input until its response
  p_accept_closes_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !reqReady);
  // R11: stray completion in idle gives no response
  p_stray_dn_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqReady && !reqValid && dnRespValid |=> !rspValid);
endmodule

// File: rtl/i2c_req_gate.sv
module i2c_req_gate
  import i2c_gate_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int BUS_W = 2,
  parameter int LEN_W = 8,
  parameter logic [BUS_W-1:0] PROT_BUS = 1,
  parameter logic [6:0] PROT_ADDR = 7'h2E,
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgValid,
  input  logic [6:0]       cfgAddr,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [BUS_W-1:0] reqBus,
  input  logic [6:0]       reqAddr,
  input  logic             reqRead,
  input  logic [LEN_W-1:0] reqLen,
  output logic             fwdValid,
  input  logic             fwdReady,
  output logic [BUS_W-1:0] fwdBus,
  output logic [6:0]       fwdAddr,
  output logic             fwdRead,
  output logic [LEN_W-1:0] fwdLen,
  input  logic             dnRespValid,
  input  logic [1:0]       dnStatus,
  output logic             rspValid,
  output logic [1:0]       rspStatus
);
  gateStrobe_t strobe;
  logic reqBlocked;

  gate_datapath #(
    .N_ENTRIES(N_ENTRIES), .BUS_W(BUS_W), .LEN_W(LEN_W),
    .PROT_BUS(PROT_BUS), .PROT_ADDR(PROT_ADDR)
  ) uDp (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid), .cfgAddr(cfgAddr),
    .reqBus(reqBus), .reqAddr(reqAddr), .reqRead(reqRead), .reqLen(reqLen),
    .dnStatus(dnStatus), .strobe(strobe), .reqBlocked(reqBlocked),
    .fwdBus(fwdBus), .fwdAddr(fwdAddr), .fwdRead(fwdRead), .fwdLen(fwdLen),
    .rspStatus(rspStatus)
  );

  gate_control uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBlocked(reqBlocked),
    .fwdReady(fwdReady), .dnRespValid(dnRespValid),
    .reqReady(reqReady), .fwdValid(fwdValid), .rspValid(rspValid),
    .strobe(strobe)
  );

  // R3: refused request answers next cycle with timeout, never forwarded
  p_block_timeout_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqBlocked |=> rspValid && rspStatus == RSP_TIMEOUT && !fwdValid);
  // R8: forwarded request holds while the master stalls
  p_fwd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && !fwdReady |=> fwdValid && $stable(fwdAddr) && $stable(fwdLen)
                              && $stable(fwdRead) && $stable(fwdBus));
  // R5: no one-byte read to the sensitive device on the guarded bus
  p_no_short_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && fwdBus == PROT_BUS && fwdAddr == PROT_ADDR |-> !(fwdRead && fwdLen == LEN_W'(1)));
  // R6: no zero-byte write to the sensitive device on the guarded bus
  p_no_empty_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && fwdBus == PROT_BUS && fwdAddr == PROT_ADDR |-> !(!fwdRead && fwdLen == '0));
  // R10: master status passed through in a single pulse
  p_dn_pass_r10: assert property (@(posedge clk) disable iff (!rstN)
    !fwdValid && !reqReady && !rspValid && dnRespValid |=> rspValid && rspStatus == $past(dnStatus));
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: tb/i2c_req_gate_tb.sv
module i2c_req_gate_tb;
  localparam int BUS_W = 2;
  localparam int LEN_W = 8;
  localparam int IDX_W = 3;
  localparam logic [BUS_W-1:0] PBUS = 2'd1;
  localparam logic [6:0] PADDR = 7'h2E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgValid = 0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [6:0] cfgAddr = '0;
  logic reqValid = 0, reqRead = 0;
  logic [BUS_W-1:0] reqBus = '0;
  logic [6:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic fwdReady = 0, dnRespValid = 0;
  logic [1:0] dnStatus = '0;
  logic reqReady, fwdValid, fwdRead, rspValid;
  logic [BUS_W-1:0] fwdBus;
  logic [6:0] fwdAddr;
  logic [LEN_W-1:0] fwdLen;
  logic [1:0] rspStatus;

  int checks = 0, errors = 0;
  logic mValid [8];
  logic [6:0] mAddr [8];

  always #10 clk = ~clk;

  i2c_req_gate u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgValid(cfgValid),
    .cfgAddr(cfgAddr), .reqValid(reqValid), .reqReady(reqReady), .reqBus(reqBus),
    .reqAddr(reqAddr), .reqRead(reqRead), .reqLen(reqLen), .fwdValid(fwdValid),
    .fwdReady(fwdReady), .fwdBus(fwdBus), .fwdAddr(fwdAddr), .fwdRead(fwdRead),
    .fwdLen(fwdLen), .dnRespValid(dnRespValid), .dnStatus(dnStatus),
    .rspValid(rspValid), .rspStatus(rspStatus)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit listed(input logic [6:0] a);
    for (int i = 0; i < 8; i++) if (mValid[i] && mAddr[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string ruleTag(input logic [BUS_W-1:0] b, input logic [6:0] a,
                                    input bit rd, input logic [LEN_W-1:0] n);
    if (b != PBUS) return "R2";
    if (!listed(a)) return "R3";
    if (a == PADDR && rd && n == 1) return "R5";
    if (a == PADDR && !rd && n == 0) return "R6";
    return "R7";
  endfunction

  function automatic bit expBlock(input string t);
    return (t == "R3" || t == "R5" || t == "R6");
  endfunction

  task automatic cfgWrite(input int idx, input bit v, input logic [6:0] a);
    @(negedge clk);
    cfgWe = 1; cfgIdx = IDX_W'(idx); cfgValid = v; cfgAddr = a;
    @(negedge clk);
    cfgWe = 0;
    mValid[idx] = v; mAddr[idx] = a;
  endtask

  task automatic doReq(input logic [BUS_W-1:0] b, input logic [6:0] a, input bit rd,
                       input logic [LEN_W-1:0] n, input int stall, input logic [1:0] dn);
    string t;
    t = ruleTag(b, a, rd, n);
    @(negedge clk);
    reqValid = 1; reqBus = b; reqAddr = a; reqRead = rd; reqLen = n;
    @(negedge clk);
    reqValid = 0;
    if (expBlock(t)) begin
      chk(rspValid && rspStatus == 2'b01 && !fwdValid, t, {rspValid, rspStatus, fwdValid}, 4'b1010);
    end else begin
      chk(fwdValid && fwdBus == b && fwdAddr == a && fwdRead == rd && fwdLen == n, t,
          {fwdValid, fwdBus, fwdAddr, fwdRead, fwdLen}, {1'b1, b, a, rd, n});
      chk(!reqReady, "R9", reqReady, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(fwdValid && fwdAddr == a && fwdLen == n, "R8", {fwdValid, fwdAddr}, {1'b1, a});
      end
      fwdReady = 1;
      @(negedge clk);
      fwdReady = 0;
      chk(!fwdValid && !reqReady && !rspValid, "R9", {fwdValid, reqReady, rspValid}, 0);
      dnRespValid = 1; dnStatus = dn;
      @(negedge clk);
      dnRespValid = 0;
      chk(rspValid && rspStatus == dn, "R10", {rspValid, rspStatus}, {1'b1, dn});
    end
    @(negedge clk);
    chk(!rspValid && reqReady, "R10", {rspValid, reqReady}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 8; i++) begin mValid[i] = 0; mAddr[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(reqReady && !fwdValid && !rspValid, "R1", {reqReady, fwdValid, rspValid}, 3'b100);
    doReq(PBUS, 7'h50, 1, 4, 0, 2'b00);               // R1: empty list refuses
    cfgWrite(0, 1, PADDR);
    cfgWrite(1, 1, 7'h50);
    cfgWrite(2, 1, 7'h51);
    doReq(2'd0, 7'h77, 0, 3, 0, 2'b00);               // R2
    doReq(2'd0, PADDR, 1, 1, 1, 2'b00);               // R2 shape ignored off-bus
    doReq(PBUS, 7'h77, 0, 3, 0, 2'b00);               // R3
    doReq(PBUS, 7'h50, 1, 4, 3, 2'b10);               // R8, R10 error pass
    doReq(PBUS, PADDR, 1, 1, 0, 2'b00);               // R5
    doReq(PBUS, PADDR, 0, 0, 0, 2'b00);               // R6
    doReq(PBUS, PADDR, 1, 0, 0, 2'b00);               // R7
    doReq(PBUS, PADDR, 1, 2, 1, 2'b00);               // R7
    doReq(PBUS, PADDR, 0, 1, 0, 2'b10);               // R7
    cfgWrite(0, 0, PADDR);                            // R4 remove
    doReq(PBUS, PADDR, 0, 3, 0, 2'b00);
    cfgWrite(7, 1, PADDR);                            // R4 re-add other slot
    doReq(PBUS, PADDR, 0, 3, 0, 2'b00);
    // R11: stray master completion while idle
    @(negedge clk);
    dnRespValid = 1; dnStatus = 2'b10;
    @(negedge clk);
    dnRespValid = 0;
    chk(!rspValid && reqReady, "R11", {rspValid, reqReady}, 2'b01);
    for (int k = 0; k < 150; k++) begin
      logic [6:0] a;
      int pick;
      pick = $urandom_range(0, 3);
      a = (pick == 0) ? PADDR : (pick == 1) ? 7'h50 : (pick == 2) ? 7'h51 : 7'($urandom);
      doReq(BUS_W'($urandom_range(0, 3)), a, 1'($urandom), LEN_W'($urandom_range(0, 3)),
            $urandom_range(0, 2), ($urandom_range(0, 1) == 1) ? 2'b10 : 2'b00);
      if (k == 75) cfgWrite(2, 0, 7'h51);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule